// File: doc/BRIEF.md
# Power Supply Monitor Interrupt Controller

This block gathers the power-management events of a small microcontroller into one maskable interrupt line. Six events are watched. The switched supply can move from the main rail to the battery, or back to the main rail. A new switched-supply measurement can differ from the previous one by more than a programmable step. A battery measurement can arrive, or can fall under a programmable threshold. The DC input comparator can report a low level. A supply sag pulse can arrive. Each event sets a sticky flag whether or not it is enabled. The interrupt output is raised while any flag is set together with its enable bit.

Software uses an 8-bit special-function-register bus with a combinational read path. It programs the enable mask, the comparison step and the battery threshold. It reads the flags, clears them by writing zeros, reads the current supply source, and can request an extra supply conversion. The conversion-request output also pulses on a fixed background period. The ADCs, comparators and power switch are outside the block and arrive as input pins.

Top module: `psm_irq_ctrl`

## Requirements
- R1: When the supply-source input falls from 1 (main) to 0 (battery), flag bit 0 is set on that clock edge. Edges are counted from the first clock after reset.
- R2: When the supply-source input rises from 0 to 1, flag bit 1 is set on that clock edge.
- R3: `irq` is high exactly when some flag bit and the matching bit of the enable register (address 0xEC, bits 5:0) are both 1. Flags are set even when their enable bit is 0.
- R4: A write to the flag register (address 0xF8) clears each flag whose written bit is 0 and leaves each flag whose written bit is 1 unchanged. Without an event or such a write, the flags hold.
- R5: If an event and a clearing write hit the same flag on the same edge, the flag ends up set.
- R6: Reading address 0xE7 returns the registered supply source in bit 0 (1 = main, 0 = battery) and zeros above.
- R7: On `vsw_valid`, flag bit 2 is set if an earlier measurement has been taken since reset and the absolute difference between the new and previous codes is strictly greater than the step register (address 0xE4). The first measurement never sets the flag.
- R8: On `bat_valid`, flag bit 3 is set. The mode bit at address 0xE8 bit 0 selects the rule: 0 means every measurement sets it, 1 means only codes strictly below the threshold register (address 0xE5) set it.
- R9: Every cycle in which `dcin_low` is high sets flag bit 4, so the flag cannot be cleared while the level persists.
- R10: A `sag_pulse` sets flag bit 5.
- R11: `conv_req` is high for one cycle after any write to address 0xE6. It is also high for one cycle every PERIOD cycles of the free-running background timer.
- R12: Reset clears the enable, flag, step, threshold and mode registers and holds `irq` and `conv_req` low. Unmapped addresses read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sfr_addr | input | 8 | Register address |
| sfr_wr | input | 1 | Write strobe |
| sfr_wdata | input | 8 | Write data |
| sfr_rdata | output | 8 | Combinational read data for `sfr_addr` |
| supply_on_main | input | 1 | Switched-supply source, 1 = main rail |
| vsw_valid | input | 1 | New switched-supply code strobe |
| vsw_code | input | 8 | Switched-supply ADC code |
| bat_valid | input | 1 | New battery code strobe |
| bat_code | input | 8 | Battery ADC code |
| dcin_low | input | 1 | DC-input comparator low level |
| sag_pulse | input | 1 | Supply sag event pulse |
| irq | output | 1 | Masked interrupt request |
| conv_req | output | 1 | Supply conversion request pulse |

## Verification
A wrong internal state shows up on the interrupt line or on the flag read-back one clock after the event that caused it. The cases that matter are a missed source edge, a lost previous measurement code, or a clear that beats a simultaneous event. The delta compare keeps hidden history: a corrupted previous code stays invisible until the next measurement strobe, and only then shows as a missing or spurious flag bit 2. Bad timer state shows as a shifted `conv_req` pulse on the next period boundary. The bench therefore compares the read data, `irq` and `conv_req` against a reference on every cycle.

// File: rtl/psm_irq_pkg.sv
package psm_irq_pkg;

  localparam int NFLAG = 6;

  localparam int BIT_BSO  = 0;
  localparam int BIT_PSR  = 1;
  localparam int BIT_VSW  = 2;
  localparam int BIT_BAT  = 3;
  localparam int BIT_DCIN = 4;
  localparam int BIT_SAG  = 5;

  localparam logic [7:0] ADDR_EN    = 8'hEC;
  localparam logic [7:0] ADDR_FLAG  = 8'hF8;
  localparam logic [7:0] ADDR_DELTA = 8'hE4;
  localparam logic [7:0] ADDR_BTHR  = 8'hE5;
  localparam logic [7:0] ADDR_START = 8'hE6;
  localparam logic [7:0] ADDR_STAT  = 8'hE7;
  localparam logic [7:0] ADDR_BCFG  = 8'hE8;

  typedef struct packed {
    logic sag;
    logic dcin;
    logic bat;
    logic vsw;
    logic psr;
    logic bso;
  } psm_evt_t;

endpackage

// File: rtl/psm_src_edge.sv
module psm_src_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic src_in,
  output logic src_q,
  output logic rise,
  output logic fall
);
  logic primed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q    <= 1'b1;
      primed_q <= 1'b0;
    end else begin
      src_q    <= src_in;
      primed_q <= 1'b1;
    end
  end

  assign rise = primed_q &  src_in & ~src_q;
  assign fall = primed_q & ~src_in &  src_q;
endmodule

// File: rtl/psm_delta_cmp.sv
module psm_delta_cmp #(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid,
  input  logic [CODE_W-1:0] code,
  input  logic [CODE_W-1:0] delta,
  output logic              evt
);
  logic [CODE_W-1:0] prev_q;
  logic              have_q;

  function automatic logic step_exceeds(input logic [CODE_W-1:0] a,
                                        input logic [CODE_W-1:0] b,
                                        input logic [CODE_W-1:0] d);
    logic [CODE_W-1:0] diff;
    diff = (a > b) ? (a - b) : (b - a);
    return diff > d;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      have_q <= 1'b0;
    end else if (valid) begin
      prev_q <= code;
      have_q <= 1'b1;
    end
  end

  assign evt = valid & have_q & step_exceeds(code, prev_q, delta);
endmodule

// File: rtl/psm_bat_cmp.sv
module psm_bat_cmp #(
  parameter int CODE_W = 8
) (
  input  logic              valid,
  input  logic [CODE_W-1:0] code,
  input  logic [CODE_W-1:0] thr,
  input  logic              below_only,
  output logic              evt
);
  function automatic logic is_low(input logic [CODE_W-1:0] c,
                                  input logic [CODE_W-1:0] t);
    return c < t;
  endfunction

  assign evt = valid & (~below_only | is_low(code, thr));
endmodule

// File: rtl/psm_conv_timer.sv
module psm_conv_timer #(
  parameter int PERIOD = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic conv_req
);
  localparam int CNT_W = (PERIOD > 2) ? $clog2(PERIOD) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             tick;

  assign tick = (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      conv_req <= 1'b0;
    end else begin
      cnt_q    <= tick ? '0 : cnt_q + 1'b1;
      conv_req <= tick | start;
    end
  end
endmodule

// File: rtl/psm_irq_ctrl.sv
module psm_irq_ctrl
  import psm_irq_pkg::*;
#(
  parameter int CODE_W = 8,
  parameter int PERIOD = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        sfr_addr,
  input  logic              sfr_wr,
  input  logic [7:0]        sfr_wdata,
  output logic [7:0]        sfr_rdata,
  input  logic              supply_on_main,
  input  logic              vsw_valid,
  input  logic [CODE_W-1:0] vsw_code,
  input  logic              bat_valid,
  input  logic [CODE_W-1:0] bat_code,
  input  logic              dcin_low,
  input  logic              sag_pulse,
  output logic              irq,
  output logic              conv_req
);
  psm_evt_t          evt;
  logic [NFLAG-1:0]  evt_vec;
  logic [NFLAG-1:0]  flags_q;
  logic [NFLAG-1:0]  en_q;
  logic [CODE_W-1:0] delta_q;
  logic [CODE_W-1:0] bthr_q;
  logic              bcfg_q;
  logic              src_q;
  logic              flag_wr;
  logic              en_wr;
  logic              start_wr;

  assign flag_wr  = sfr_wr && (sfr_addr == ADDR_FLAG);
  assign en_wr    = sfr_wr && (sfr_addr == ADDR_EN);
  assign start_wr = sfr_wr && (sfr_addr == ADDR_START);

  psm_src_edge src_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .src_in (supply_on_main),
    .src_q  (src_q),
    .rise   (evt.psr),
    .fall   (evt.bso)
  );

  psm_delta_cmp #(.CODE_W(CODE_W)) vsw_i (
    .clk   (clk),
    .rst_n (rst_n),
    .valid (vsw_valid),
    .code  (vsw_code),
    .delta (delta_q),
    .evt   (evt.vsw)
  );

  psm_bat_cmp #(.CODE_W(CODE_W)) bat_i (
    .valid      (bat_valid),
    .code       (bat_code),
    .thr        (bthr_q),
    .below_only (bcfg_q),
    .evt        (evt.bat)
  );

  psm_conv_timer #(.PERIOD(PERIOD)) tmr_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start_wr),
    .conv_req (conv_req)
  );

  assign evt.dcin = dcin_low;
  assign evt.sag  = sag_pulse;
  assign evt_vec  = evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= '0;
      delta_q <= '0;
      bthr_q  <= '0;
      bcfg_q  <= 1'b0;
    end else if (sfr_wr) begin
      case (sfr_addr)
        ADDR_EN:    en_q    <= sfr_wdata[NFLAG-1:0];
        ADDR_DELTA: delta_q <= sfr_wdata[CODE_W-1:0];
        ADDR_BTHR:  bthr_q  <= sfr_wdata[CODE_W-1:0];
        ADDR_BCFG:  bcfg_q  <= sfr_wdata[0];
        default:    ;
      endcase
    end
  end

  genvar g;
  generate
    for (g = 0; g < NFLAG; g++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          flags_q[g] <= 1'b0;
        else if (evt_vec[g])
          flags_q[g] <= 1'b1;
        else if (flag_wr && !sfr_wdata[g])
          flags_q[g] <= 1'b0;
      end
    end
  endgenerate

  assign irq = |(flags_q & en_q);

  always_comb begin
    sfr_rdata = '0;
    case (sfr_addr)
      ADDR_EN:    sfr_rdata[NFLAG-1:0]  = en_q;
      ADDR_FLAG:  sfr_rdata[NFLAG-1:0]  = flags_q;
      ADDR_DELTA: sfr_rdata[CODE_W-1:0] = delta_q;
      ADDR_BTHR:  sfr_rdata[CODE_W-1:0] = bthr_q;
      ADDR_BCFG:  sfr_rdata[0]          = bcfg_q;
      ADDR_STAT:  sfr_rdata[0]          = src_q;
      default:    sfr_rdata = '0;
    endcase
  end
endmodule

// File: rtl/psm_irq_ctrl_chk.sv
module psm_irq_ctrl_chk #(
  parameter int NF = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic [NF-1:0] evt_vec,
  input logic [NF-1:0] flags_q,
  input logic [NF-1:0] en_q,
  input logic          flag_wr,
  input logic          en_wr,
  input logic          irq
);
  AST_BSO_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    evt_vec[0] |=> flags_q[0]); // R1
  AST_PSR_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    evt_vec[1] |=> flags_q[1]); // R2
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |-> !irq); // R3
  AST_IRQ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !flag_wr && !en_wr) |=> irq); // R3
  AST_FLAGS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_wr && evt_vec == '0) |=> (flags_q == $past(flags_q))); // R4
  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_vec != '0) |=> ((flags_q & $past(evt_vec)) == $past(evt_vec))); // R5
endmodule

bind psm_irq_ctrl psm_irq_ctrl_chk #(.NF(psm_irq_pkg::NFLAG)) chk_i (
  .clk     (clk),
  .rst_n   (rst_n),
  .evt_vec (evt_vec),
  .flags_q (flags_q),
  .en_q    (en_q),
  .flag_wr (flag_wr),
  .en_wr   (en_wr),
  .irq     (irq)
);

// File: tb/psm_irq_ctrl_tb.sv
module psm_irq_ctrl_tb_top;
  localparam int PER = 37;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] sfr_addr = 8'hF8;
  logic       sfr_wr = 1'b0;
  logic [7:0] sfr_wdata = 8'h00;
  logic [7:0] sfr_rdata;
  logic       supply_on_main = 1'b1;
  logic       vsw_valid = 1'b0;
  logic [7:0] vsw_code = 8'h00;
  logic       bat_valid = 1'b0;
  logic [7:0] bat_code = 8'h00;
  logic       dcin_low = 1'b0;
  logic       sag_pulse = 1'b0;
  logic       irq;
  logic       conv_req;

  int n_run = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  psm_irq_ctrl #(.CODE_W(8), .PERIOD(PER)) dut_i (
    .clk(clk), .rst_n(rst_n), .sfr_addr(sfr_addr), .sfr_wr(sfr_wr),
    .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata),
    .supply_on_main(supply_on_main), .vsw_valid(vsw_valid), .vsw_code(vsw_code),
    .bat_valid(bat_valid), .bat_code(bat_code), .dcin_low(dcin_low),
    .sag_pulse(sag_pulse), .irq(irq), .conv_req(conv_req)
  );

  // reference model state
  int m_en = 0, m_flags = 0, m_delta = 0, m_thr = 0, m_cfg = 0;
  int m_src = 1, m_primed = 0, m_prev = 0, m_have = 0, m_cnt = 0, m_conv = 0;

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int exp_read(input int a);
    case (a)
      8'hEC: return m_en;
      8'hF8: return m_flags;
      8'hE4: return m_delta;
      8'hE5: return m_thr;
      8'hE8: return m_cfg;
      8'hE7: return m_src;
      default: return 0;
    endcase
  endfunction

  function automatic string req_of_addr(input int a);
    case (a)
      8'hEC: return "R3";
      8'hE4: return "R7";
      8'hE5, 8'hE8: return "R8";
      8'hE7: return "R6";
      8'hF8: return "R4";
      default: return "R12";
    endcase
  endfunction

  always @(posedge clk) begin
    int ev, d;
    if (!rst_n) begin
      m_en = 0; m_flags = 0; m_delta = 0; m_thr = 0; m_cfg = 0;
      m_src = 1; m_primed = 0; m_prev = 0; m_have = 0; m_cnt = 0; m_conv = 0;
    end else begin
      ev = 0;
      if (m_primed != 0 && int'(supply_on_main) != m_src)
        ev |= supply_on_main ? 2 : 1;
      m_src = supply_on_main; m_primed = 1;
      if (vsw_valid) begin
        d = int'(vsw_code) - m_prev;
        if (d < 0) d = -d;
        if (m_have != 0 && d > m_delta) ev |= 4;
        m_prev = vsw_code; m_have = 1;
      end
      if (bat_valid && (m_cfg == 0 || int'(bat_code) < m_thr)) ev |= 8;
      if (dcin_low) ev |= 16;
      if (sag_pulse) ev |= 32;
      m_conv = (m_cnt == PER - 1) ? 1 : 0;
      m_cnt = (m_cnt == PER - 1) ? 0 : m_cnt + 1;
      if (sfr_wr) begin
        case (sfr_addr)
          8'hEC: m_en = sfr_wdata & 8'h3F;
          8'hF8: m_flags = m_flags & sfr_wdata;
          8'hE4: m_delta = sfr_wdata;
          8'hE5: m_thr = sfr_wdata;
          8'hE8: m_cfg = sfr_wdata & 1;
          8'hE6: m_conv = 1;
          default: ;
        endcase
      end
      m_flags = m_flags | ev;
    end
    #3;
    check("R3", irq, ((m_flags & m_en) != 0) ? 1 : 0);
    check("R11", conv_req, m_conv);
    if (sfr_addr == 8'hF8) begin
      check("R1", sfr_rdata[0], m_flags & 1);
      check("R2", sfr_rdata[1], (m_flags >> 1) & 1);
      check("R7", sfr_rdata[2], (m_flags >> 2) & 1);
      check("R8", sfr_rdata[3], (m_flags >> 3) & 1);
      check("R9", sfr_rdata[4], (m_flags >> 4) & 1);
      check("R10", sfr_rdata[5], (m_flags >> 5) & 1);
      check("R4", sfr_rdata[7:6], 0);
    end else begin
      check(req_of_addr(sfr_addr), sfr_rdata, exp_read(sfr_addr));
    end
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); sfr_wr = 1'b1; sfr_addr = a; sfr_wdata = d;
    @(negedge clk); sfr_wr = 1'b0; sfr_addr = 8'hF8;
  endtask

  task automatic flags_are(input string req, input int exp);
    sfr_addr = 8'hF8; #1;
    check(req, sfr_rdata, exp);
  endtask

  task automatic vsw(input logic [7:0] c);
    @(negedge clk); vsw_valid = 1'b1; vsw_code = c;
    @(negedge clk); vsw_valid = 1'b0;
  endtask

  task automatic bat(input logic [7:0] c);
    @(negedge clk); bat_valid = 1'b1; bat_code = c;
    @(negedge clk); bat_valid = 1'b0;
  endtask

  task automatic finish_run;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check("R12", irq, 0);
    check("R12", conv_req, 0);
    flags_are("R12", 0);
    rst_n = 1'b1;
    @(negedge clk);
    sfr_addr = 8'hEC; #1; check("R12", sfr_rdata, 0);
    sfr_addr = 8'h55; #1; check("R12", sfr_rdata, 0);

    // R1/R3: flag sets with enable off, irq follows enable
    wr(8'hEC, 8'h00);
    supply_on_main = 1'b0;
    @(negedge clk);
    flags_are("R1", 8'h01);
    check("R3", irq, 0);
    wr(8'hEC, 8'h01);
    check("R3", irq, 1);
    // R4: write 1 keeps, write 0 clears
    wr(8'hF8, 8'hFF);
    flags_are("R4", 8'h01);
    wr(8'hF8, 8'hFE);
    flags_are("R4", 8'h00);
    check("R3", irq, 0);
    // R2
    supply_on_main = 1'b1;
    @(negedge clk);
    flags_are("R2", 8'h02);
    wr(8'hF8, 8'h00);
    // R5: event beats clear
    @(negedge clk); sfr_wr = 1'b1; sfr_addr = 8'hF8; sfr_wdata = 8'h00; sag_pulse = 1'b1;
    @(negedge clk); sfr_wr = 1'b0; sag_pulse = 1'b0;
    flags_are("R5", 8'h20);
    wr(8'hF8, 8'h00);
    // R7: delta compare
    wr(8'hE4, 8'd10);
    vsw(8'd100); flags_are("R7", 0);
    vsw(8'd105); flags_are("R7", 0);
    vsw(8'd116); flags_are("R7", 8'h04);
    wr(8'hF8, 8'h00);
    vsw(8'd106); flags_are("R7", 0);
    vsw(8'd95);  flags_are("R7", 8'h04);
    wr(8'hF8, 8'h00);
    // R8: battery modes
    bat(8'd200); flags_are("R8", 8'h08);
    wr(8'hF8, 8'h00);
    wr(8'hE8, 8'h01);
    wr(8'hE5, 8'd50);
    bat(8'd60); flags_are("R8", 0);
    bat(8'd50); flags_are("R8", 0);
    bat(8'd49); flags_are("R8", 8'h08);
    wr(8'hF8, 8'h00);
    // R9: level holds flag against clear
    @(negedge clk); dcin_low = 1'b1;
    @(negedge clk);
    wr(8'hF8, 8'h00);
    flags_are("R9", 8'h10);
    dcin_low = 1'b0;
    wr(8'hF8, 8'h00);
    flags_are("R9", 0);
    // R11: software start
    @(negedge clk); sfr_wr = 1'b1; sfr_addr = 8'hE6; sfr_wdata = 8'h00;
    @(negedge clk); sfr_wr = 1'b0; #1;
    check("R11", conv_req, 1);
    // R6: status
    sfr_addr = 8'hE7; #1; check("R6", sfr_rdata, 1);
    supply_on_main = 1'b0;
    @(negedge clk); #1; check("R6", sfr_rdata, 0);
    supply_on_main = 1'b1;
    @(negedge clk);
    // random traffic, reference compared every cycle
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] addrs [7];
      addrs = '{8'hEC, 8'hF8, 8'hE4, 8'hE5, 8'hE6, 8'hE7, 8'hE8};
      @(negedge clk);
      sfr_wr    = ($urandom_range(0, 3) == 0);
      sfr_addr  = ($urandom_range(0, 2) == 0) ? addrs[$urandom_range(0, 6)] : 8'hF8;
      sfr_wdata = 8'($urandom);
      if ($urandom_range(0, 15) == 0) supply_on_main = ~supply_on_main;
      vsw_valid = ($urandom_range(0, 5) == 0);
      vsw_code  = 8'($urandom);
      bat_valid = ($urandom_range(0, 7) == 0);
      bat_code  = 8'($urandom);
      if ($urandom_range(0, 9) == 0) dcin_low = ~dcin_low;
      sag_pulse = ($urandom_range(0, 11) == 0);
    end
    @(negedge clk);
    sfr_wr = 1'b0; vsw_valid = 1'b0; bat_valid = 1'b0; sag_pulse = 1'b0; dcin_low = 1'b0;
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule